// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

This block is a memory-mapped controller for one bank of 32 general-purpose pins, grouped as four 8-bit ports. Software sets each pin's direction and output level, selects whether a pin is handed to a dedicated peripheral, and reads back pin levels. Every input passes through a synchronizer. A per-pin 2-bit field chooses which edges latch a sticky status bit. That same field is also the pin's interrupt enable. The OR of all status bits drives a single interrupt line.

Access is over a simple synchronous register bus with byte and halfword transfers. A request is a one-cycle `bus_valid` pulse. The block never applies back-pressure: every request is taken in the cycle it is presented. A read answers exactly one cycle later with a one-cycle `rd_valid` pulse. There is no ready signal on the response, so the consumer must capture it in that cycle. Halfwords are little-endian: the lower address holds bits 7:0.

Top module: `gpio_edge_bank`

## Requirements
- R1: The byte address map is as follows. Pin select is at 0x00–0x03, direction at 0x08–0x0B, data at 0x0C–0x0F, status at 0x10–0x13 and edge mask at 0x14–0x1B. In each one-bit-per-pin register, port p is the byte at base+p, and pin bit b of that port is global pin 8p+b. A halfword access ignores address bit 0 and covers bytes addr and addr+1, the lower address in bits 7:0. Addresses 0x04–0x07 and 0x1C–0x1F read as zero, and writes to them change nothing.
- R2: Pin select bits are stored and driven on `pin_sel`: 0 means normal GPIO and 1 means dedicated peripheral. They change only on a write.
- R3: A direction bit of 1 makes the pin an output and 0 makes it an input, shown on `pin_oe`. `pin_out` shows the stored output latch. Both change only on a write.
- R4: A data read returns the stored output bit for output pins and the synchronized input level for input pins. A data write updates only the output latch.
- R5: A read request produces `rd_valid` high for exactly the next cycle, with the data in `rd_data`. In every other cycle `rd_valid` is low and `rd_data` is zero. The upper byte is zero for byte reads.
- R6: Port p's edge field halfword is at 0x14+2p, and pin n of that port uses bits 2n+1:2n. The field values are: 00 disabled, 01 falling edges only, 10 rising edges only, 11 both edges.
- R7: Inputs pass through two synchronizer flops. A pin change that is sampled at clock edge k sets its status bit at edge k+2, if the pin's field selects that edge.
- R8: Status is read per port as a byte at 0x10+p. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R9: If a clear and a new edge hit the same status bit in the same cycle, the bit stays set.
- R10: `irq` is high whenever any status bit is set. Status bits latch whatever the pin direction, but only when the pin's field is nonzero.
- R11: After reset, all registers, `pin_oe`, `pin_out`, `pin_sel`, `irq` and `rd_valid` are zero.
- R12: Writing zero to all edge fields and then 0xFF to all status bytes leaves `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | One-cycle request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address in the register window |
| bus_half | input | 1 | 1 = halfword access, 0 = byte |
| bus_wdata | input | 16 | Write data, bits 7:0 for the lower address |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 16 | Read response data |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output latch |
| pin_oe | output | 32 | Output enable, one bit per pin |
| pin_sel | output | 32 | Peripheral select, one bit per pin |
| irq | output | 1 | Combined interrupt |

## Verification
The bound checker tests these properties on every cycle:
- the read response follows its request by one cycle;
- `pin_oe`, `pin_out` and `pin_sel` hold still when no write is made;
- a status bit only ever appears after a detected edge, and only ever drops after a bus write;
- an edge that coincides with a clear keeps its bit.

The address decode, the exact bit placement in the packed edge fields, the choice of edge for each field value, and the mix of latch and pin level on data reads can only be shown by the bench's scenarios and its reference model. That model is compared against the design on every clock, through directed port sequences and a stretch of pseudo-random traffic.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int PORT_W = 8;
  localparam int PORTS  = 4;
  localparam int PINS   = PORT_W * PORTS;
  localparam int FLD_W  = 2;
  localparam int ADDR_W = 5;
  localparam int BUS_W  = 16;
  localparam int LANES  = BUS_W / PORT_W;

  // word index = addr[4:2]; byte in word = port number
  localparam logic [2:0] W_SEL    = 3'd0;
  localparam logic [2:0] W_DIR    = 3'd2;
  localparam logic [2:0] W_DAT    = 3'd3;
  localparam logic [2:0] W_STS    = 3'd4;
  localparam logic [2:0] W_MSK_LO = 3'd5;
  localparam logic [2:0] W_MSK_HI = 3'd6;

  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] addr;
    logic [PORT_W-1:0] data;
  } lane_t;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync
  import gpio_bank_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PINS-1:0]       pin_in,
  input  logic [FLD_W*PINS-1:0] mask,
  output logic [PINS-1:0]       level,
  output logic [PINS-1:0]       evt
);
  logic [STAGES-1:0][PINS-1:0] chain;
  logic [PINS-1:0]             level_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain   <= '0;
      level_d <= '0;
    end else begin
      chain[0] <= pin_in;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      level_d <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];

  for (genvar i = 0; i < PINS; i++) begin : g_edge
    logic rise, fall;
    assign rise   = level[i] & ~level_d[i];
    assign fall   = ~level[i] & level_d[i];
    assign evt[i] = (rise & mask[FLD_W*i+1]) | (fall & mask[FLD_W*i]);
  end
endmodule

// File: rtl/gpio_bank_status.sv
module gpio_bank_status
  import gpio_bank_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  lane_t [LANES-1:0]      wr_lane,
  input  logic  [PINS-1:0]       evt,
  output logic  [PINS-1:0]       status_q
);
  logic [PINS-1:0] clr;

  always_comb begin
    clr = '0;
    for (int l = 0; l < LANES; l++)
      if (wr_lane[l].en && wr_lane[l].addr[4:2] == W_STS)
        clr[wr_lane[l].addr[1:0]*PORT_W +: PORT_W] = wr_lane[l].data;
  end

  // a fresh edge overrides a simultaneous clear
  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr) | evt;
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  lane_t [LANES-1:0]       wr_lane,
  input  logic                    rd_req,
  input  logic                    rd_half,
  input  logic  [ADDR_W-1:0]      rd_addr_lo,
  input  logic  [ADDR_W-1:0]      rd_addr_hi,
  input  logic  [PINS-1:0]        level,
  input  logic  [PINS-1:0]        status_q,
  output logic  [PINS-1:0]        sel_q,
  output logic  [PINS-1:0]        dir_q,
  output logic  [PINS-1:0]        dout_q,
  output logic  [FLD_W*PINS-1:0]  mask_q,
  output logic                    rd_valid,
  output logic  [BUS_W-1:0]       rd_data
);
  logic [PINS-1:0] data_view;
  assign data_view = (dout_q & dir_q) | (level & ~dir_q);

  function automatic logic [PORT_W-1:0] peek(input logic [ADDR_W-1:0] a);
    case (a[4:2])
      W_SEL:    return sel_q[a[1:0]*PORT_W +: PORT_W];
      W_DIR:    return dir_q[a[1:0]*PORT_W +: PORT_W];
      W_DAT:    return data_view[a[1:0]*PORT_W +: PORT_W];
      W_STS:    return status_q[a[1:0]*PORT_W +: PORT_W];
      W_MSK_LO: return mask_q[a[1:0]*PORT_W +: PORT_W];
      W_MSK_HI: return mask_q[(a[1:0]+PORTS)*PORT_W +: PORT_W];
      default:  return '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      dir_q  <= '0;
      dout_q <= '0;
      mask_q <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_lane[l].en) begin
          case (wr_lane[l].addr[4:2])
            W_SEL:    sel_q[wr_lane[l].addr[1:0]*PORT_W +: PORT_W]  <= wr_lane[l].data;
            W_DIR:    dir_q[wr_lane[l].addr[1:0]*PORT_W +: PORT_W]  <= wr_lane[l].data;
            W_DAT:    dout_q[wr_lane[l].addr[1:0]*PORT_W +: PORT_W] <= wr_lane[l].data;
            W_MSK_LO: mask_q[wr_lane[l].addr[1:0]*PORT_W +: PORT_W] <= wr_lane[l].data;
            W_MSK_HI: mask_q[(wr_lane[l].addr[1:0]+PORTS)*PORT_W +: PORT_W] <= wr_lane[l].data;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (rd_req) begin
      rd_valid <= 1'b1;
      rd_data  <= {rd_half ? peek(rd_addr_hi) : {PORT_W{1'b0}}, peek(rd_addr_lo)};
    end else begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end
  end
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_bank_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_half,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic              rd_valid,
  output logic [BUS_W-1:0]  rd_data,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic [PINS-1:0]   pin_sel,
  output logic              irq
);
  lane_t [LANES-1:0]      wr_lane;
  logic  [ADDR_W-1:0]     addr_lo, addr_hi;
  logic  [PINS-1:0]       level, evt, status_q;
  logic  [FLD_W*PINS-1:0] mask_q;

  assign addr_lo = bus_half ? {bus_addr[ADDR_W-1:1], 1'b0} : bus_addr;
  assign addr_hi = {bus_addr[ADDR_W-1:1], 1'b1};

  always_comb begin
    wr_lane[0].en   = bus_valid & bus_write;
    wr_lane[0].addr = addr_lo;
    wr_lane[0].data = bus_wdata[PORT_W-1:0];
    wr_lane[1].en   = bus_valid & bus_write & bus_half;
    wr_lane[1].addr = addr_hi;
    wr_lane[1].data = bus_wdata[BUS_W-1:PORT_W];
  end

  gpio_bank_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .mask(mask_q),
    .level(level), .evt(evt)
  );

  gpio_bank_status u_status (
    .clk(clk), .rst_n(rst_n), .wr_lane(wr_lane), .evt(evt), .status_q(status_q)
  );

  gpio_bank_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_lane(wr_lane),
    .rd_req(bus_valid & ~bus_write), .rd_half(bus_half),
    .rd_addr_lo(addr_lo), .rd_addr_hi(addr_hi),
    .level(level), .status_q(status_q),
    .sel_q(pin_sel), .dir_q(pin_oe), .dout_q(pin_out), .mask_q(mask_q),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign irq = |status_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            bus_valid,
  input logic            bus_write,
  input logic            rd_valid,
  input logic [PINS-1:0] pin_oe,
  input logic [PINS-1:0] pin_out,
  input logic [PINS-1:0] pin_sel,
  input logic            irq,
  input logic [PINS-1:0] status_q,
  input logic [PINS-1:0] evt
);
  // R5
  rd_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rd_valid);
  // R5
  rd_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !rd_valid);
  // R3
  dir_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_write) |=> ($stable(pin_oe) && $stable(pin_out)));
  // R2
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_write) |=> $stable(pin_sel));
  // R7
  set_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(status_q) |-> ((status_q & ~$past(status_q) & ~$past(evt)) == '0));
  // R8
  clear_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~status_q & $past(status_q)) != '0) |-> $past(bus_valid && bus_write));
  // R9
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(evt) != '0) |-> (($past(evt) & ~status_q) == '0));
  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(evt) != '0));
  // R11
  reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq && !rd_valid && pin_oe == '0 && pin_sel == '0));
endmodule

bind gpio_edge_bank gpio_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .rd_valid(rd_valid), .pin_oe(pin_oe), .pin_out(pin_out), .pin_sel(pin_sel),
  .irq(irq), .status_q(status_q), .evt(evt)
);

// File: tb/gpio_edge_bank_tb.sv
module gpio_edge_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0, bus_half = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        rd_valid, irq;
  logic [15:0] rd_data;
  logic [31:0] pin_in = '0, pin_out, pin_oe, pin_sel;

  always #5 clk = ~clk;

  gpio_edge_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_half(bus_half), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_sel(pin_sel), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;

  task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_sel, m_dir, m_dout, m_sts, m_s1, m_s2, m_sd, m_ev, m_clr;
  logic [63:0] m_msk;
  logic        m_rv;
  logic [15:0] m_rd;
  int          m_base;

  function automatic logic [7:0] m_byte(input int a);
    logic [31:0] view;
    int p;
    view = (m_dout & m_dir) | (m_s2 & ~m_dir);
    p = a % 4;
    if (a < 4)       return m_sel[p*8 +: 8];
    else if (a < 8)  return 8'h00;
    else if (a < 12) return m_dir[p*8 +: 8];
    else if (a < 16) return view[p*8 +: 8];
    else if (a < 20) return m_sts[p*8 +: 8];
    else if (a < 28) return m_msk[(a-20)*8 +: 8];
    else             return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel = 0; m_dir = 0; m_dout = 0; m_sts = 0; m_s1 = 0; m_s2 = 0; m_sd = 0;
      m_msk = 0; m_rv = 0; m_rd = 0;
    end else begin
      for (int i = 0; i < 32; i++)
        m_ev[i] = (m_s2[i] && !m_sd[i] && m_msk[2*i+1]) || (!m_s2[i] && m_sd[i] && m_msk[2*i]);
      m_base = bus_half ? (int'(bus_addr) & ~1) : int'(bus_addr);
      m_rv = 0; m_rd = 0; m_clr = 0;
      if (bus_valid && !bus_write) begin
        m_rv = 1;
        m_rd[7:0] = m_byte(m_base);
        if (bus_half) m_rd[15:8] = m_byte(m_base + 1);
      end
      if (bus_valid && bus_write) begin
        for (int j = 0; j < (bus_half ? 2 : 1); j++) begin
          int a;
          logic [7:0] d;
          a = m_base + j;
          d = bus_wdata[j*8 +: 8];
          if (a < 4)                 m_sel[(a%4)*8 +: 8]  = d;
          else if (a >= 8 && a < 12) m_dir[(a%4)*8 +: 8]  = d;
          else if (a >= 12 && a < 16) m_dout[(a%4)*8 +: 8] = d;
          else if (a >= 16 && a < 20) m_clr[(a%4)*8 +: 8] = d;
          else if (a >= 20 && a < 28) m_msk[(a-20)*8 +: 8] = d;
        end
      end
      m_sts = (m_sts & ~m_clr) | m_ev;
      m_sd = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      cmp(pin_sel, m_sel, "R2 pin_sel");
      cmp(pin_oe, m_dir, "R3 pin_oe");
      cmp(pin_out, m_dout, "R3 pin_out");
      cmp({31'b0, irq}, {31'b0, m_sts != 0}, "R10 irq");
      cmp({31'b0, rd_valid}, {31'b0, m_rv}, "R5 rd_valid");
      cmp({16'b0, rd_data}, {16'b0, m_rd}, "R1 rd_data");
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(input int a, input bit half, input int d);
    bus_valid = 1; bus_write = 1; bus_addr = 5'(a); bus_half = half; bus_wdata = 16'(d);
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input int a, input bit half, input int exp, input string tag);
    bus_valid = 1; bus_write = 0; bus_addr = 5'(a); bus_half = half;
    @(negedge clk);
    bus_valid = 0;
    cmp({16'b0, rd_data}, 32'(exp), tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin(input int i, input bit v);
    pin_in[i] = v;
    idle(3);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // ---------------- scenarios ----------------
  logic [31:0] lfsr = 32'h1BADF00D;

  initial begin
    idle(3);
    rst_n = 1;
    // R11 reset state
    cmp(pin_oe, 0, "R11 pin_oe"); cmp(pin_out, 0, "R11 pin_out");
    cmp(pin_sel, 0, "R11 pin_sel"); cmp({31'b0, irq}, 0, "R11 irq");
    rd(16, 1, 0, "R11 status");
    rd(20, 1, 0, "R11 mask");

    // R2 / R1 select with byte and halfword writes
    wr(0, 1, 16'hA55A); wr(2, 0, 8'h3C); wr(3, 0, 8'hC3);
    cmp(pin_sel, 32'hC33CA55A, "R2 sel value");
    rd(3, 1, 16'hC33C, "R1 halfword ignores bit 0");
    rd(1, 0, 8'hA5, "R1 byte lane 1");

    // R3 direction and output latch
    wr(8, 1, 16'h00FF); wr(10, 1, 16'hF0F0);
    wr(12, 1, 16'h1234); wr(14, 1, 16'hABCD);
    cmp(pin_oe, 32'hF0F000FF, "R3 pin_oe");
    cmp(pin_out, 32'hABCD1234, "R3 pin_out");

    // R4 data readback mixes latch and pin level
    pin_in = 32'h5555AAAA; idle(3);
    rd(12, 1, 16'hAA34, "R4 data lo");
    rd(14, 1, 16'hA5C5, "R4 data hi");
    cmp(pin_out, 32'hABCD1234, "R4 latch unchanged by pins");

    // R1 reserved and out-of-window addresses
    wr(4, 1, 16'hFFFF); wr(28, 1, 16'hFFFF); wr(30, 0, 8'hFF);
    rd(4, 1, 0, "R1 reserved reads zero");
    rd(28, 1, 0, "R1 beyond window reads zero");
    rd(0, 1, 16'hA55A, "R1 reserved write harmless");

    // R12 init: zero fields, clear status
    pin_in = 0; idle(4);
    for (int p = 0; p < 4; p++) wr(20 + 2*p, 1, 0);
    for (int p = 0; p < 4; p++) wr(16 + p, 0, 8'hFF);
    cmp({31'b0, irq}, 0, "R12 irq after init");

    // R6/R7 rising only on port0 pin3 (an output pin: R10)
    wr(20, 1, 16'h0080);
    pin_in[3] = 1; idle(2);
    cmp({31'b0, irq}, 0, "R7 not yet set after two edges");
    idle(1);
    cmp({31'b0, irq}, 1, "R7 set on third edge");
    rd(16, 0, 8'h08, "R10 output pin latches");
    pin(3, 0);
    rd(16, 0, 8'h08, "R6 rising only");
    // R8 write 0 has no effect, write 1 clears
    wr(16, 0, 8'hF7);
    rd(16, 0, 8'h08, "R8 zero bits keep");
    wr(16, 0, 8'h08);
    rd(16, 0, 8'h00, "R8 one clears");
    cmp({31'b0, irq}, 0, "R10 irq drops");
    pin(3, 1); wr(16, 0, 8'h08); pin(3, 0);
    rd(16, 0, 8'h00, "R6 rising field ignores fall");

    // R6 falling only: port1 pin0 -> halfword 0x16 bits 1:0
    wr(22, 1, 16'h0001);
    pin(8, 1);
    rd(17, 0, 8'h00, "R6 falling ignores rise");
    pin(8, 0);
    rd(17, 0, 8'h01, "R6 falling sets");
    wr(17, 0, 8'h01);

    // R6 both: port2 pin7 -> halfword 0x18 bits 15:14
    wr(24, 1, 16'hC000);
    pin(23, 1);
    rd(18, 0, 8'h80, "R6 both rise");
    wr(18, 0, 8'h80);
    pin(23, 0);
    rd(18, 0, 8'h80, "R6 both fall");

    // R9 clear collides with a new edge
    pin_in[23] = 1; idle(2);
    wr(18, 0, 8'h80);
    rd(18, 0, 8'h80, "R9 edge wins over clear");
    wr(18, 0, 8'h80);
    rd(18, 0, 8'h00, "R9 later clear works");

    // R6 byte write into upper mask byte of port3: pin 28 rising
    wr(27, 0, 8'h02);
    rd(26, 1, 16'h0200, "R6 port3 field placement");
    pin(28, 1); pin(31, 1);
    rd(19, 0, 8'h10, "R6 disabled pin31 ignored");
    wr(16, 1, 16'hFFFF); wr(18, 1, 16'hFFFF);
    rd(16, 1, 0, "R8 halfword clear");

    // pseudo-random traffic compared to the model each cycle
    for (int c = 0; c < 3000; c++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      bus_valid = lfsr[0] & lfsr[5];
      bus_write = lfsr[1];
      bus_half  = lfsr[2];
      bus_addr  = lfsr[10:6];
      bus_wdata = lfsr[31:16];
      if (lfsr[13:11] == 3'd0) pin_in[lfsr[18:14]] = ~pin_in[lfsr[18:14]];
      @(negedge clk);
    end
    bus_valid = 0; bus_write = 0;

    // R12 final init sequence
    idle(4);
    for (int p = 0; p < 4; p++) wr(20 + 2*p, 1, 0);
    idle(4);
    for (int p = 0; p < 4; p++) wr(16 + p, 0, 8'hFF);
    cmp({31'b0, irq}, 0, "R12 irq low after init");
    rd(16, 1, 0, "R12 status clear lo");
    rd(18, 1, 0, "R12 status clear hi");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule